// File: doc/BRIEF.md
# Return Address Stack with Fault Reset

This block keeps the return addresses of a small 8-bit processor core. The core pushes its program counter on every call and interrupt entry, and it pops on every return. The block shows the current top entry on a dedicated output, so the program counter logic can load it on the same cycle as the pop.

The stack holds sixteen 15-bit addresses. Two conditions count as faults: a push into a stack that is already full, and a pop from a stack that is empty. Each fault sets its own sticky status flag. When fault reset is enabled, the block also sends a one-cycle reset request to the core's reset controller. When fault reset is disabled, the stack keeps running. An overflowing push overwrites the oldest slot, and an underflowing pop only moves the pointer.

A core reset empties the stack but leaves the fault flags alone, so that software can find out why the reset happened. Only a power-on reset or a software clear removes the flags.

Top module: `retstack_top`

## Requirements
- R1: Pushed addresses (15 bits wide, 16 entries deep) come back in last-in first-out order. `tos` shows the most recently pushed entry that is still on the stack one cycle after each push or pop.
- R2: `tos` reads 0 whenever the stack holds no entry.
- R3: A push (push=1, pop=0) with 16 entries already stored sets `ovf_flag` on the next cycle. It replaces the oldest entry, so the following pops return the 16 newest addresses, newest first.
- R4: A pop (pop=1, push=0) on an empty stack sets `unf_flag` on the next cycle. The stack stays empty and `tos` stays 0.
- R5: If push and pop are both 1 while the stack holds entries, `push_addr` replaces the top entry and the depth stays the same. On an empty stack, the pair acts as a plain push and raises no fault.
- R6: While `fault_rst_en`=1, every overflow or underflow event makes `rst_req` high for exactly the next cycle.
- R7: While `fault_rst_en`=0, fault events set the flags but leave `rst_req` low.
- R8: Each fault flag stays set until `flag_clr`=1. In a cycle where a new event and the clear arrive together, the event wins.
- R9: `core_rst`=1 empties the stack on the next edge and keeps both fault flags as they were.
- R10: `rst_n`=0 empties the stack and clears both flags and `rst_req`.
- R11: `core_rst` has priority over push and pop in the same cycle. Neither the stack nor the flags change because of those strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| core_rst | input | 1 | Synchronous core reset, empties the stack |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| push_addr | input | 15 | Address to store |
| flag_clr | input | 1 | Clears both fault flags |
| fault_rst_en | input | 1 | Enables the reset request on a fault |
| tos | output | 15 | Top of stack, 0 when empty |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| rst_req | output | 1 | One-cycle reset request to the core |

## Verification
The assertions assume that every strobe is sampled on the clock edge. They also assume that `core_rst` acts as a synchronous input whose effect shows one cycle later. The bench keeps to this by changing every input only on the falling edge and checking the outputs on the next falling edge, after the registered effect has settled. The overflow and underflow checks expect a fault to come only from a single strobe, never from the push-and-pop pair. The stimulus therefore includes the pair on an empty stack to confirm that this case raises no fault.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stk_op_e;

  // Strobe pair to operation; a core reset masks both strobes.
  function automatic stk_op_e decode_op(input logic hold, input logic psh, input logic pp);
    if (hold) return OP_IDLE;
    case ({psh, pp})
      2'b10:   return OP_PUSH;
      2'b01:   return OP_POP;
      2'b11:   return OP_SWAP;
      default: return OP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_rst,
  input  logic             push,
  input  logic             pop,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic             empty,
  output logic             ovf_evt,
  output logic             unf_evt
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;
  stk_op_e          op;

  assign op      = decode_op(core_rst, push, pop);
  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign ovf_evt = (op == OP_PUSH) && full;
  assign unf_evt = (op == OP_POP) && empty;
  assign wr_en   = (op == OP_PUSH) || (op == OP_SWAP);
  assign wr_idx  = ((op == OP_SWAP) && !empty) ? ptr_dec(ptr_q) : ptr_q;
  assign rd_idx  = ptr_dec(ptr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (core_rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      case (op)
        OP_PUSH: begin
          ptr_q <= ptr_inc(ptr_q);
          if (!full) cnt_q <= cnt_q + 1'b1;
        end
        OP_POP: begin
          ptr_q <= ptr_dec(ptr_q);
          if (!empty) cnt_q <= cnt_q - 1'b1;
        end
        OP_SWAP: begin
          if (empty) begin
            ptr_q <= ptr_inc(ptr_q);
            cnt_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R1
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !core_rst && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5
  swap_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !core_rst && !empty) |=> $stable(cnt_q));

  // R9
  core_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> empty);

endmodule

// File: rtl/rstk_mem.sv
module rstk_mem #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 15,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DEPTH*DATA_W-1:0] slots_flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 slot_q <= '0;
      else if (wr_en && (wr_idx == PTR_W'(i)))    slot_q <= wr_data;
    end
    assign slots_flat[i*DATA_W +: DATA_W] = slot_q;
  end

  assign rd_data = slots_flat[int'(rd_idx)*DATA_W +: DATA_W];

endmodule

// File: rtl/rstk_fault.sv
module rstk_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic unf_evt,
  input  logic flag_clr,
  input  logic fault_rst_en,
  output logic ovf_flag,
  output logic unf_flag,
  output logic rst_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      ovf_flag <= ovf_evt | (ovf_flag & ~flag_clr);
      unf_flag <= unf_evt | (unf_flag & ~flag_clr);
      rst_req  <= fault_rst_en & (ovf_evt | unf_evt);
    end
  end

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  // R4
  unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> unf_flag);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  // R8
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag && !flag_clr) |=> unf_flag);

  // R6
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(fault_rst_en) && ($past(ovf_evt) || $past(unf_evt))));

  // R7
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_rst_en |=> !rst_req);

endmodule

// File: rtl/retstack_top.sv
module retstack_top #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 15,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rst,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              flag_clr,
  input  logic              fault_rst_en,
  output logic [ADDR_W-1:0] tos,
  output logic              ovf_flag,
  output logic              unf_flag,
  output logic              rst_req
);

  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] rd_idx;
  logic             empty;
  logic             ovf_evt;
  logic             unf_evt;
  logic [ADDR_W-1:0] rd_data;

  rstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .push(push), .pop(pop),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx), .empty(empty),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  rstk_mem #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(push_addr), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  rstk_fault u_fault (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .flag_clr(flag_clr), .fault_rst_en(fault_rst_en),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .rst_req(rst_req)
  );

  assign tos = empty ? '0 : rd_data;

  // R2
  empty_tos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (tos == '0));

  // R11
  core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> ((tos == '0) && !rst_req));

  // R1
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !core_rst) |=> (tos == $past(push_addr)));

endmodule

// File: tb/sim_retstack_top.sv
`timescale 1ns/1ps
module sim_retstack_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_rst = 1'b0;
  logic        push = 1'b0;
  logic        pop = 1'b0;
  logic [14:0] push_addr = '0;
  logic        flag_clr = 1'b0;
  logic        fault_rst_en = 1'b0;
  logic [14:0] tos;
  logic        ovf_flag, unf_flag, rst_req;

  always #2.5 clk = ~clk;

  retstack_top u0 (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .push(push), .pop(pop),
    .push_addr(push_addr), .flag_clr(flag_clr), .fault_rst_en(fault_rst_en),
    .tos(tos), .ovf_flag(ovf_flag), .unf_flag(unf_flag), .rst_req(rst_req)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Independent reference: a queue, newest at the back.
  int unsigned mq[$];
  bit m_ovf = 0, m_unf = 0, m_req = 0;

  task automatic cmp(input string tag, input int unsigned act, input int unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned m_tos();
    return (mq.size() == 0) ? 0 : mq[mq.size()-1];
  endfunction

  task automatic model_step(input bit cr, input bit pu, input bit po, input bit cl,
                            input bit en, input int unsigned d);
    bit eo = 0, eu = 0;
    if (cr) mq.delete();
    else if (pu && po) begin
      if (mq.size() == 0) mq.push_back(d);
      else mq[mq.size()-1] = d;
    end else if (pu) begin
      if (mq.size() == 16) begin eo = 1; void'(mq.pop_front()); end
      mq.push_back(d);
    end else if (po) begin
      if (mq.size() == 0) eu = 1;
      else void'(mq.pop_back());
    end
    m_ovf = eo | (m_ovf & ~cl);
    m_unf = eu | (m_unf & ~cl);
    m_req = en & (eo | eu);
  endtask

  // Drive at a falling edge, then check at the next falling edge.
  task automatic step(input string tag, input bit cr, input bit pu, input bit po,
                      input bit cl, input bit en, input int unsigned d);
    @(negedge clk);
    core_rst = cr; push = pu; pop = po; flag_clr = cl; fault_rst_en = en;
    push_addr = 15'(d);
    model_step(cr, pu, po, cl, en, d);
    @(negedge clk);
    core_rst = 0; push = 0; pop = 0; flag_clr = 0;
    cmp({tag, " tos"}, tos, m_tos());
    cmp({tag, " ovf"}, ovf_flag, m_ovf);
    cmp({tag, " unf"}, unf_flag, m_unf);
    cmp({tag, " req"}, rst_req, m_req);
  endtask

  // {core_rst,push,pop,clr,en, data[14:0], exp_tos[14:0], exp_ovf,exp_unf,exp_req}
  localparam int NV = 17;
  localparam logic [37:0] VEC [NV] = '{
    {5'b01000, 15'h0100, 15'h0100, 3'b000},  // R1 push
    {5'b01000, 15'h0200, 15'h0200, 3'b000},  // R1 push
    {5'b01100, 15'h0333, 15'h0333, 3'b000},  // R5 replace top
    {5'b00100, 15'h0000, 15'h0100, 3'b000},  // R1 pop
    {5'b00000, 15'h0000, 15'h0100, 3'b000},  // idle
    {5'b00100, 15'h0000, 15'h0000, 3'b000},  // R2 empty reads 0
    {5'b00100, 15'h0000, 15'h0000, 3'b010},  // R4 R7 underflow, no req
    {5'b01100, 15'h0444, 15'h0444, 3'b010},  // R5 pair on empty = push
    {5'b00010, 15'h0000, 15'h0444, 3'b000},  // R8 clear
    {5'b00101, 15'h0000, 15'h0000, 3'b000},  // pop last
    {5'b00101, 15'h0000, 15'h0000, 3'b011},  // R6 underflow req
    {5'b00001, 15'h0000, 15'h0000, 3'b010},  // R6 req one cycle
    {5'b11001, 15'h0555, 15'h0000, 3'b010},  // R11 core_rst beats push
    {5'b01000, 15'h7FFF, 15'h7FFF, 3'b010},  // R1 full-width value
    {5'b10000, 15'h0000, 15'h0000, 3'b010},  // R9 core_rst keeps flag
    {5'b00110, 15'h0000, 15'h0000, 3'b010},  // R8 event beats clear
    {5'b00010, 15'h0000, 15'h0000, 3'b000}   // R8 clear
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    cmp("R10 reset tos", tos, 0);
    cmp("R10 reset ovf", ovf_flag, 0);
    cmp("R10 reset unf", unf_flag, 0);
    cmp("R10 reset req", rst_req, 0);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      step($sformatf("vec%0d", i), v[37], v[36], v[35], v[34], v[33], int'(v[32:18]));
      cmp($sformatf("vec%0d table tos", i), tos, v[17:3]);
      cmp($sformatf("vec%0d table ovf", i), ovf_flag, v[2]);
      cmp($sformatf("vec%0d table unf", i), unf_flag, v[1]);
      cmp($sformatf("vec%0d table req", i), rst_req, v[0]);
    end

    // R1 fill all 16 entries with fault reset enabled
    for (int i = 1; i <= 16; i++) step("R1 fill", 0, 1, 0, 0, 1, i * 3 + 1);
    cmp("R1 no overflow at full", ovf_flag, 0);
    // R3 R6 overflowing push
    step("R3 R6 overflow push", 0, 1, 0, 0, 1, 15'h1234);
    cmp("R6 req on overflow", rst_req, 1);
    step("R6 req drops", 0, 0, 0, 0, 1, 0);
    cmp("R6 req single cycle", rst_req, 0);
    // R3 wrapped contents come back newest first
    for (int i = 0; i < 16; i++) step("R3 drain after wrap", 0, 0, 1, 0, 0, 0);
    cmp("R2 empty after drain", tos, 0);
    cmp("R3 ovf still set", ovf_flag, 1);

    // R7 overflow with fault reset disabled
    for (int i = 0; i < 17; i++) step("R7 fill", 0, 1, 0, 0, 0, 100 + i);
    cmp("R7 no req", rst_req, 0);
    // R9 core reset empties but keeps flags
    step("R9 core reset", 1, 0, 0, 0, 0, 0);
    cmp("R9 ovf kept", ovf_flag, 1);
    step("R9 push after core reset", 0, 1, 0, 0, 0, 15'h0ABC);

    // R10 power-on reset mid-run
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    mq.delete(); m_ovf = 0; m_unf = 0; m_req = 0;
    @(negedge clk);
    cmp("R10 por tos", tos, 0);
    cmp("R10 por ovf", ovf_flag, 0);
    cmp("R10 por unf", unf_flag, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule